// File: doc/BRIEF.md
# Acquire/Release Memory Fence Controller

This block stands in front of a GPU first-level request coalescer and enforces acquire/release ordering on the requests that pass through it. Each request carries three qualifiers (kernel scope, acquire, release) and a context number. Depending on the mix of qualifiers and on how many writebacks are still in flight, the block either forwards the request to the coalescer and passes the coalescer's answer back, or answers it directly. Once a request is accepted, the block asks a cache walk engine to invalidate the cache, to write it back, or to do both.

Two counters hold the outstanding invalidate and writeback lines. Each counter is loaded with the walk's line count when a walk starts and is decremented by a completion pulse from the memory side. While any writeback is outstanding, the normal issue path is held off. Kernel-end requests are noted per context, and all of them are reported together in one pulse when the writeback count reaches zero.

Top module: `fence_ctrl`

## Requirements
- R1: After reset, both counters read zero, issue_en is high, and walk_start, retry, kend_valid and underflow_err are low.
- R2: A kernel-scope request is answered by the block itself with status 0 (issued) and co_valid kept low in two cases: while wb_count is nonzero, or when it also carries release and wb_count is zero. Every other request is forwarded on co_valid in the same cycle, and co_status is returned unchanged on rsp_status.
- R3: A forwarded request that the coalescer refuses (co_status not 0, for example 1 = aliased) starts no walk and changes no counter or kernel-end record.
- R4: An accepted forwarded request with acquire and without release, kernel-scope or not, gives walk_start with walk_op = 2'b01 one cycle later. In the same cycle, inv_count grows by walk_lines. Bit 0 of walk_op means invalidate and bit 1 means writeback.
- R5: An accepted plain release gives walk_op = 2'b10 and adds walk_lines to wb_count one cycle later.
- R6: An accepted request with both acquire and release gives walk_op = 2'b11 and adds walk_lines to both counters.
- R7: A kernel-scope release seen while wb_count is zero records its context and starts walk_op = 2'b10. If walk_lines is zero, kend_valid pulses in the next cycle with that context's bit set in kend_mask.
- R8: While wb_count is nonzero, a kernel-scope acquire starts an invalidate only if inv_count is zero, and a kernel-scope release is recorded without starting a walk.
- R9: Each wb_done or inv_done pulse lowers its counter by one. retry pulses in the cycle after any completion pulse.
- R10: When wb_count reaches zero, kend_valid pulses for one cycle. kend_mask then holds one bit per recorded context (bit n for context n), and the record is emptied.
- R11: issue_en is high exactly when no writeback is outstanding.
- R12: A completion pulse that arrives while its counter is zero leaves the counter at zero and sets underflow_err, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kern | input | 1 | Request has kernel scope |
| req_acq | input | 1 | Request has acquire semantics |
| req_rel | input | 1 | Request has release semantics |
| req_ctx | input | $clog2(NUM_CTX) | Context number of the request |
| rsp_status | output | 2 | Status returned to the requester (0 = issued) |
| co_valid | output | 1 | Request forwarded to the coalescer |
| co_status | input | 2 | Coalescer's answer to the forwarded request |
| walk_lines | input | CNT_W | Number of lines a walk started now will cover |
| walk_start | output | 1 | Walk command pulse |
| walk_op | output | 2 | Walk kind: bit 0 invalidate, bit 1 writeback |
| wb_done | input | 1 | One writeback line completed |
| inv_done | input | 1 | One invalidate line completed |
| wb_count | output | CNT_W | Outstanding writeback lines |
| inv_count | output | CNT_W | Outstanding invalidate lines |
| issue_en | output | 1 | Normal issue path enabled |
| retry | output | 1 | Stalled requesters may retry |
| kend_valid | output | 1 | Kernel-end completion report |
| kend_mask | output | NUM_CTX | Contexts whose kernel end completes |
| underflow_err | output | 1 | Sticky counter underflow flag |

## Verification
The routing results co_valid and rsp_status are combinational. The bench reads them one time unit after it drives a request on the falling edge, before the next rising edge. The walk command, the counters, issue_en, retry and the kernel-end report all appear exactly one rising edge after the stimulus, so every such check is taken one time unit after that edge, and the request or completion pulse is removed at the same moment. To confirm that a pulse lasts only one cycle, the bench checks kend_valid again one cycle later, low.

// File: rtl/fence_pkg.sv
package fence_pkg;
   localparam logic [1:0] ST_ISSUED = 2'd0;
   localparam logic [1:0] OP_INV    = 2'b01;
   localparam logic [1:0] OP_WB     = 2'b10;
   localparam int         OP_W      = 2;
   typedef struct packed {
      logic fwd;
      logic do_inv;
      logic do_wb;
      logic rec;
   } fence_act_t;
endpackage

// File: rtl/fence_classify.sv
module fence_classify
   import fence_pkg::*;
(
   input  logic       vld,
   input  logic       kern,
   input  logic       acq,
   input  logic       rel,
   input  logic       wb_busy,
   input  logic       inv_busy,
   input  logic [1:0] co_st,
   output fence_act_t act
);
   logic local_ans;
   always_comb begin
      act       = '0;
      local_ans = vld && kern && (wb_busy || rel);
      act.fwd   = vld && !local_ans;
      if (local_ans) begin
         if (wb_busy) begin
            act.do_inv = acq && !inv_busy;
            act.rec    = rel;
         end else begin
            act.rec   = 1'b1;
            act.do_wb = 1'b1;
         end
      end else if (act.fwd && co_st == ST_ISSUED) begin
         act.do_inv = acq;
         act.do_wb  = rel;
      end
   end
endmodule

// File: rtl/fence_ctr.sv
module fence_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         add_en,
   input  logic [W-1:0] add_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_nxt,
   output logic         uflow
);
   always_comb begin
      uflow   = dec && (cnt == '0);
      cnt_nxt = cnt;
      if (add_en) cnt_nxt = cnt_nxt + add_val;
      if (dec && !uflow) cnt_nxt = cnt_nxt - W'(1);
   end
   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_nxt;
   end
endmodule

// File: rtl/fence_kend.sv
module fence_kend #(
   parameter int NUM_CTX = 8,
   localparam int CW = $clog2(NUM_CTX)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rec_en,
   input  logic [CW-1:0]      rec_ctx,
   input  logic               drained,
   output logic               rpt_valid,
   output logic [NUM_CTX-1:0] rpt_mask
);
   logic [NUM_CTX-1:0] pend, pend_nxt, hit;
   for (genvar g = 0; g < NUM_CTX; g++) begin : g_dec
      assign hit[g] = rec_en && (rec_ctx == CW'(g));
   end
   assign pend_nxt = pend | hit;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= '0;
         rpt_valid <= 1'b0;
         rpt_mask  <= '0;
      end else if (drained && |pend_nxt) begin
         pend      <= '0;
         rpt_valid <= 1'b1;
         rpt_mask  <= pend_nxt;
      end else begin
         pend      <= pend_nxt;
         rpt_valid <= 1'b0;
         rpt_mask  <= '0;
      end
   end
endmodule

// File: rtl/fence_ctrl.sv
module fence_ctrl
   import fence_pkg::*;
#(
   parameter int NUM_CTX = 8,
   parameter int CNT_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_kern,
   input  logic                       req_acq,
   input  logic                       req_rel,
   input  logic [$clog2(NUM_CTX)-1:0] req_ctx,
   output logic [1:0]                 rsp_status,
   output logic                       co_valid,
   input  logic [1:0]                 co_status,
   input  logic [CNT_W-1:0]           walk_lines,
   output logic                       walk_start,
   output logic [OP_W-1:0]            walk_op,
   input  logic                       wb_done,
   input  logic                       inv_done,
   output logic [CNT_W-1:0]           wb_count,
   output logic [CNT_W-1:0]           inv_count,
   output logic                       issue_en,
   output logic                       retry,
   output logic                       kend_valid,
   output logic [NUM_CTX-1:0]         kend_mask,
   output logic                       underflow_err
);
   if (NUM_CTX < 2 || NUM_CTX > 64) begin : g_bad_ctx
      $error("fence_ctrl: NUM_CTX must lie in 2..64");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("fence_ctrl: CNT_W must be at least 2");
   end

   fence_act_t       act;
   logic [CNT_W-1:0] wb_nxt, inv_nxt;
   logic             wb_uf, inv_uf;

   fence_classify u_cls (
      .vld(req_valid), .kern(req_kern), .acq(req_acq), .rel(req_rel),
      .wb_busy(wb_count != '0), .inv_busy(inv_count != '0),
      .co_st(co_status), .act(act)
   );

   assign co_valid   = act.fwd;
   assign rsp_status = act.fwd ? co_status : ST_ISSUED;

   fence_ctr #(.W(CNT_W)) u_wb (
      .clk(clk), .rst_n(rst_n), .add_en(act.do_wb), .add_val(walk_lines),
      .dec(wb_done), .cnt(wb_count), .cnt_nxt(wb_nxt), .uflow(wb_uf)
   );
   fence_ctr #(.W(CNT_W)) u_inv (
      .clk(clk), .rst_n(rst_n), .add_en(act.do_inv), .add_val(walk_lines),
      .dec(inv_done), .cnt(inv_count), .cnt_nxt(inv_nxt), .uflow(inv_uf)
   );

   fence_kend #(.NUM_CTX(NUM_CTX)) u_kend (
      .clk(clk), .rst_n(rst_n), .rec_en(act.rec), .rec_ctx(req_ctx),
      .drained(wb_nxt == '0), .rpt_valid(kend_valid), .rpt_mask(kend_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         walk_start    <= 1'b0;
         walk_op       <= '0;
         issue_en      <= 1'b1;
         retry         <= 1'b0;
         underflow_err <= 1'b0;
      end else begin
         walk_start    <= act.do_inv || act.do_wb;
         walk_op       <= {act.do_wb, act.do_inv};
         issue_en      <= (wb_nxt == '0);
         retry         <= wb_done || inv_done;
         underflow_err <= underflow_err || wb_uf || inv_uf;
      end
   end
endmodule

// File: rtl/fence_ctrl_chk.sv
module fence_ctrl_chk #(
   parameter int NUM_CTX = 8,
   parameter int CNT_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_kern,
   input logic [1:0]         rsp_status,
   input logic               co_valid,
   input logic [1:0]         co_status,
   input logic               walk_start,
   input logic               wb_done,
   input logic               inv_done,
   input logic [CNT_W-1:0]   wb_count,
   input logic               issue_en,
   input logic               retry,
   input logic               kend_valid,
   input logic [NUM_CTX-1:0] kend_mask,
   input logic               underflow_err
);
   p_local_ans_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kern && wb_count != '0) |-> (!co_valid && rsp_status == 2'd0));
   p_pass_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
      co_valid |-> (rsp_status == co_status));
   p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (co_valid && co_status != 2'd0) |=> !walk_start);
   p_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_done || inv_done) |=> retry);
   p_kend_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
      kend_valid |-> (wb_count == '0 && kend_mask != '0));
   p_issue_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      issue_en == (wb_count == '0));
   p_sticky_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
      underflow_err |=> underflow_err);
endmodule

bind fence_ctrl fence_ctrl_chk #(.NUM_CTX(NUM_CTX), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kern(req_kern),
   .rsp_status(rsp_status), .co_valid(co_valid), .co_status(co_status),
   .walk_start(walk_start), .wb_done(wb_done), .inv_done(inv_done),
   .wb_count(wb_count), .issue_en(issue_en), .retry(retry),
   .kend_valid(kend_valid), .kend_mask(kend_mask), .underflow_err(underflow_err)
);

// File: tb/fence_ctrl_bench.sv
`timescale 1ns/1ps
module fence_ctrl_bench;
   localparam int NC = 8;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_kern = 0, req_acq = 0, req_rel = 0;
   logic [2:0] req_ctx = '0;
   logic [1:0] rsp_status, co_status = 2'd0;
   logic co_valid, walk_start, issue_en, retry, kend_valid, underflow_err;
   logic [1:0] walk_op;
   logic [CW-1:0] walk_lines = '0, wb_count, inv_count;
   logic wb_done = 0, inv_done = 0;
   logic [NC-1:0] kend_mask;
   int checks = 0, fails = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   fence_ctrl #(.NUM_CTX(NC), .CNT_W(CW)) u_fence_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kern(req_kern),
      .req_acq(req_acq), .req_rel(req_rel), .req_ctx(req_ctx),
      .rsp_status(rsp_status), .co_valid(co_valid), .co_status(co_status),
      .walk_lines(walk_lines), .walk_start(walk_start), .walk_op(walk_op),
      .wb_done(wb_done), .inv_done(inv_done), .wb_count(wb_count),
      .inv_count(inv_count), .issue_en(issue_en), .retry(retry),
      .kend_valid(kend_valid), .kend_mask(kend_mask),
      .underflow_err(underflow_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Drive one request on the falling edge; check routing before the rising edge.
   task automatic send(input bit k, input bit a, input bit r, input int ctx,
                       input int st, input int lines, input bit exp_fwd,
                       input int exp_rsp);
      @(negedge clk);
      req_valid = 1; req_kern = k; req_acq = a; req_rel = r;
      req_ctx = 3'(ctx); co_status = 2'(st); walk_lines = CW'(lines);
      #1;
      chk("R2 co_valid", int'(co_valid), int'(exp_fwd));
      chk("R2 rsp_status", int'(rsp_status), exp_rsp);
      @(posedge clk); #1;
      req_valid = 0; req_kern = 0; req_acq = 0; req_rel = 0; co_status = 2'd0;
   endtask

   task automatic done_pulse(input bit w, input bit i);
      @(negedge clk);
      wb_done = w; inv_done = i;
      @(posedge clk); #1;
      wb_done = 0; inv_done = 0;
   endtask

   task automatic t_reset;
      chk("R1 wb_count", int'(wb_count), 0);
      chk("R1 inv_count", int'(inv_count), 0);
      chk("R1 issue_en", int'(issue_en), 1);
      chk("R1 walk_start", int'(walk_start), 0);
      chk("R1 kend_valid", int'(kend_valid), 0);
      chk("R1 underflow_err", int'(underflow_err), 0);
      chk("R1 retry", int'(retry), 0);
   endtask

   task automatic t_acquire;
      send(0, 1, 0, 0, 0, 3, 1, 0);
      chk("R4 walk_start", int'(walk_start), 1);
      chk("R4 walk_op", int'(walk_op), 1);
      chk("R4 inv_count", int'(inv_count), 3);
      chk("R4 wb_count", int'(wb_count), 0);
      chk("R11 issue_en after acquire", int'(issue_en), 1);
      for (int n = 2; n >= 0; n--) begin
         done_pulse(0, 1);
         chk("R9 inv_count dec", int'(inv_count), n);
         chk("R9 retry", int'(retry), 1);
      end
      // kernel acquire with wb idle goes to coalescer; refused -> no action
      send(1, 1, 0, 1, 2, 4, 1, 2);
      chk("R3 no walk on refuse", int'(walk_start), 0);
      chk("R3 inv unchanged", int'(inv_count), 0);
      send(1, 1, 0, 1, 0, 2, 1, 0);
      chk("R4 kernel acq op", int'(walk_op), 1);
      chk("R4 kernel acq inv", int'(inv_count), 2);
      done_pulse(0, 1); done_pulse(0, 1);
      chk("R9 inv drained", int'(inv_count), 0);
   endtask

   task automatic t_refuse;
      send(0, 0, 1, 0, 1, 5, 1, 1);
      chk("R3 walk_start", int'(walk_start), 0);
      chk("R3 wb_count", int'(wb_count), 0);
      chk("R3 issue_en", int'(issue_en), 1);
   endtask

   task automatic t_release;
      send(0, 0, 1, 0, 0, 2, 1, 0);
      chk("R5 walk_start", int'(walk_start), 1);
      chk("R5 walk_op", int'(walk_op), 2);
      chk("R5 wb_count", int'(wb_count), 2);
      chk("R11 issue_en low", int'(issue_en), 0);
      send(1, 0, 1, 5, 0, 2, 0, 0);
      chk("R8 kernel rel no walk", int'(walk_start), 0);
      chk("R8 wb unchanged", int'(wb_count), 2);
      send(1, 1, 0, 0, 0, 2, 0, 0);
      chk("R8 kernel acq walk", int'(walk_start), 1);
      chk("R8 kernel acq op", int'(walk_op), 1);
      chk("R8 inv_count", int'(inv_count), 2);
      send(1, 1, 0, 0, 0, 2, 0, 0);
      chk("R8 no second inv", int'(walk_start), 0);
      chk("R8 inv held", int'(inv_count), 2);
      done_pulse(1, 0);
      chk("R9 wb dec", int'(wb_count), 1);
      chk("R10 no early report", int'(kend_valid), 0);
      done_pulse(1, 0);
      chk("R10 kend_valid", int'(kend_valid), 1);
      chk("R10 kend_mask", int'(kend_mask), 32);
      chk("R11 issue_en back", int'(issue_en), 1);
      @(posedge clk); #1;
      chk("R10 one-cycle pulse", int'(kend_valid), 0);
      done_pulse(0, 1); done_pulse(0, 1);
   endtask

   task automatic t_acqrel;
      send(0, 1, 1, 0, 0, 2, 1, 0);
      chk("R6 walk_op", int'(walk_op), 3);
      chk("R6 wb_count", int'(wb_count), 2);
      chk("R6 inv_count", int'(inv_count), 2);
      chk("R11 issue_en low", int'(issue_en), 0);
      done_pulse(1, 1); done_pulse(1, 1);
      chk("R9 both drained wb", int'(wb_count), 0);
      chk("R9 both drained inv", int'(inv_count), 0);
      chk("R10 no report when empty", int'(kend_valid), 0);
   endtask

   task automatic t_kend;
      send(1, 0, 1, 2, 3, 0, 0, 0);
      chk("R7 walk_op", int'(walk_op), 2);
      chk("R7 wb stays 0", int'(wb_count), 0);
      chk("R7 kend_valid", int'(kend_valid), 1);
      chk("R7 kend_mask", int'(kend_mask), 4);
      send(1, 0, 1, 1, 0, 1, 0, 0);
      chk("R7 wb started", int'(wb_count), 1);
      chk("R7 no report yet", int'(kend_valid), 0);
      send(1, 0, 1, 6, 0, 1, 0, 0);
      done_pulse(1, 0);
      chk("R10 batched valid", int'(kend_valid), 1);
      chk("R10 batched mask", int'(kend_mask), 8'h42);
   endtask

   task automatic t_underflow;
      done_pulse(1, 0);
      chk("R12 err set", int'(underflow_err), 1);
      chk("R12 wb stays 0", int'(wb_count), 0);
      @(posedge clk); #1;
      chk("R12 err sticky", int'(underflow_err), 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      t_reset();
      t_acquire();
      t_refuse();
      t_release();
      t_acqrel();
      t_kend();
      t_underflow();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule